// File: doc/BRIEF.md
# GPIO Expander Register and Interrupt Core

This block is the register file and pin logic behind an eight-pin serial-attached I/O expander. A bus front end, which lives elsewhere, turns serial transactions into single-cycle read and write strobes with an 8-bit register address. The core holds seven byte registers:

- device configuration
- direction
- output style
- change status
- interrupt mask
- pin data
- fan speed

From these it produces an output enable and an output level for every pin.

Input pins are resynchronised and watched for edges. Every edge on an input pin is recorded in the status register. A pin whose mask bit is set, while the global interrupt enable is on, also pulls the active-low open-drain alert line. A read of the status register clears the alert, and so does a completed alert-response handshake reported by the bus front end.

In fan mode the upper four pins stop acting as general-purpose pins. They drive active-low speed-select and shutdown lines taken from the fan-speed register. In this mode those four pins raise neither status bits nor alerts.

Top module: `gpio_xpdr_core`

## Requirements
- R1: After reset, registers at 00h (config), 01h (direction), 02h (output style), 03h (status), 04h (mask) and 06h (fan) read 00h, and alert_n is 1. The data register holds FFh, which a read of 05h shows once all pins are outputs.
- R2: Reads of 00h..06h return the registers. Any other address reads 00h, and writes to it are ignored. The status register at 03h ignores writes.
- R3: The pin drive depends on direction bit 1 (output) and output-style bit. With style bit 1 (push-pull), pin_oe=1 and pin_out=data. With style bit 0 (open-drain), pin_oe=~data and pin_out=0. A pin with direction bit 0 is an input: pin_oe=0 and pin_out=0.
- R4: Any rising or falling edge on an input pin sets its status bit, regardless of config bit 0 and the mask. Edges on output pins set nothing.
- R5: A status read returns the bits held before the read and then clears them. A change that lands on the same clock edge as the read stays set.
- R6: alert_n goes to 0 only when all of these hold: config bit 0 (interrupt enable) is 1, the pin's mask bit is 1, the pin is an input, and that pin changes.
- R7: An asserted alert returns to 1 after a status read or an ara_ack pulse. A qualifying change on that same edge keeps it asserted. ara_ack leaves the status bits unchanged.
- R8: With config bit 1 (fan mode) set, pins 7..4 are always driven (pin_oe=1). Pin 4+k carries the inverse of fan register bit k, where bit 0 is shutdown, bit 1 FS0, bit 2 FS1 and bit 3 FS2. Direction and output-style bits for those pins are ignored.
- R9: In fan mode, edges on pins 7..4 set no status bits and raise no alert. Pins 3..0 keep their normal behaviour.
- R10: A read of 05h returns the synchronised pin level for input pins and the data register bit for output pins.
- R11: A pin edge is synchronised through two flops plus a history flop. It reaches status and alert on the third rising clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at 03h) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| ara_ack | input | 1 | One-cycle pulse: alert-response handshake done |
| pin_in | input | 8 | Raw pad input levels |
| pin_oe | output | 8 | Per-pin pad output enable |
| pin_out | output | 8 | Per-pin pad output level |
| alert_n | output | 1 | Active-low alert; the pad drives low only when 0 |

## Verification
The bench targets several corner cases:

- **Status read racing a new edge.** A design that clears blindly would lose the new bit.
- **Handshake racing a qualifying change.** A design that lets clear win would drop an alert the host never saw.
- **Edges on masked pins, output pins and fan-mode upper pins.** A design that gates status by the mask or ignores direction would report phantom changes. A design that forgets fan mode would raise alerts from the speed lines.
- **Synchroniser latency.** Alert is sampled one cycle before and on the expected edge, so a missing or extra stage shows up directly.
- **Open-drain output.** The drive table covers open-drain pins, where an inverted enable would fight the bus.

// File: rtl/gpio_xpdr_pkg.sv
package gpio_xpdr_pkg;

    localparam int REG_W = 8;

    localparam logic [7:0] ADR_CFG  = 8'h00;
    localparam logic [7:0] ADR_DIR  = 8'h01;
    localparam logic [7:0] ADR_OSTY = 8'h02;
    localparam logic [7:0] ADR_STAT = 8'h03;
    localparam logic [7:0] ADR_MASK = 8'h04;
    localparam logic [7:0] ADR_DATA = 8'h05;
    localparam logic [7:0] ADR_FAN  = 8'h06;

    localparam int CFG_IE_BIT  = 0;
    localparam int CFG_FAN_BIT = 1;

    localparam logic [REG_W-1:0] RST_ZERO = '0;
    localparam logic [REG_W-1:0] RST_DATA = '1;

    typedef enum logic [0:0] {
        ALRT_IDLE = 1'b0,
        ALRT_PEND = 1'b1
    } alert_state_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] edge_seen
);
    localparam int ARM_CNT = STAGES + 1;
    localparam int CNT_W   = $clog2(ARM_CNT + 1);

    logic [W-1:0]     stg_q [STAGES];
    logic [W-1:0]     hist_q;
    logic [CNT_W-1:0] warm_q;
    logic             armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q[0] <= '0;
        end else begin
            stg_q[0] <= raw;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[s] <= '0;
            end else begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            warm_q <= '0;
        end else begin
            hist_q <= stg_q[STAGES-1];
            if (!armed) begin
                warm_q <= warm_q + 1'b1;
            end
        end
    end

    assign armed     = (warm_q == CNT_W'(ARM_CNT));
    assign lvl       = stg_q[STAGES-1];
    assign edge_seen = armed ? (stg_q[STAGES-1] ^ hist_q) : '0;

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive (
    input  logic dir_out,
    input  logic push_pull,
    input  logic dat,
    input  logic fan_own,
    input  logic fan_lvl,
    output logic oe,
    output logic out
);
    always_comb begin
        if (fan_own) begin
            oe  = 1'b1;
            out = fan_lvl;
        end else if (dir_out) begin
            if (push_pull) begin
                oe  = 1'b1;
                out = dat;
            end else begin
                oe  = ~dat;
                out = 1'b0;
            end
        end else begin
            oe  = 1'b0;
            out = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_alert_fsm.sv
module gpio_alert_fsm
    import gpio_xpdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clear,
    output logic alert_n
);
    alert_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ALRT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALRT_IDLE: if (raise) state_d = ALRT_PEND;
            ALRT_PEND: if (clear && !raise) state_d = ALRT_IDLE;
            default:   state_d = ALRT_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ALRT_PEND: alert_n = 1'b0;
            default:   alert_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/gpio_xpdr_core.sv
module gpio_xpdr_core
    import gpio_xpdr_pkg::*;
#(
    parameter int PIN_N       = 8,
    parameter int FAN_N       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_addr,
    input  logic [PIN_N-1:0] reg_wdata,
    output logic [PIN_N-1:0] reg_rdata,
    input  logic             ara_ack,
    input  logic [PIN_N-1:0] pin_in,
    output logic [PIN_N-1:0] pin_oe,
    output logic [PIN_N-1:0] pin_out,
    output logic             alert_n
);
    localparam int FAN_BASE = PIN_N - FAN_N;
    localparam logic [PIN_N-1:0] FAN_PINS = {{FAN_N{1'b1}}, {FAN_BASE{1'b0}}};

    logic [PIN_N-1:0] cfg_q, dir_q, osty_q, stat_q, mask_q, data_q, fan_q;
    logic [PIN_N-1:0] fan_sel, is_in, sync_lvl, raw_edge, chg_in, fan_lvl;
    logic [PIN_N-1:0] data_view;
    logic             fan_en, ie, stat_rd, alert_set, alert_clr;

    assign fan_en  = cfg_q[CFG_FAN_BIT];
    assign ie      = cfg_q[CFG_IE_BIT];
    assign fan_sel = fan_en ? FAN_PINS : '0;
    assign is_in   = ~dir_q & ~fan_sel;
    assign stat_rd = reg_rd && (reg_addr == ADR_STAT);

    // writable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= RST_ZERO;
            dir_q  <= RST_ZERO;
            osty_q <= RST_ZERO;
            mask_q <= RST_ZERO;
            data_q <= RST_DATA;
            fan_q  <= RST_ZERO;
        end else if (reg_wr) begin
            case (reg_addr)
                ADR_CFG:  cfg_q  <= reg_wdata;
                ADR_DIR:  dir_q  <= reg_wdata;
                ADR_OSTY: osty_q <= reg_wdata;
                ADR_MASK: mask_q <= reg_wdata;
                ADR_DATA: data_q <= reg_wdata;
                ADR_FAN:  fan_q  <= reg_wdata;
                default:  ;
            endcase
        end
    end

    // input synchroniser and edge detector
    gpio_in_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       (pin_in),
        .lvl       (sync_lvl),
        .edge_seen (raw_edge)
    );

    assign chg_in = raw_edge & is_in;

    // status: read clears, a simultaneous change survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= RST_ZERO;
        end else begin
            stat_q <= (stat_rd ? RST_ZERO : stat_q) | chg_in;
        end
    end

    assign alert_set = ie && ((chg_in & mask_q) != '0);
    assign alert_clr = stat_rd || ara_ack;

    gpio_alert_fsm u_alert (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise   (alert_set),
        .clear   (alert_clr),
        .alert_n (alert_n)
    );

    // fan levels and per-pin drivers
    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        if (i >= FAN_BASE) begin : g_fan
            assign fan_lvl[i] = ~fan_q[i-FAN_BASE];
        end else begin : g_gp
            assign fan_lvl[i] = 1'b0;
        end

        gpio_pin_drive u_drv (
            .dir_out   (dir_q[i]),
            .push_pull (osty_q[i]),
            .dat       (data_q[i]),
            .fan_own   (fan_sel[i]),
            .fan_lvl   (fan_lvl[i]),
            .oe        (pin_oe[i]),
            .out       (pin_out[i])
        );
    end

    assign data_view = (is_in & sync_lvl) | (~is_in & data_q);

    always_comb begin
        case (reg_addr)
            ADR_CFG:  reg_rdata = cfg_q;
            ADR_DIR:  reg_rdata = dir_q;
            ADR_OSTY: reg_rdata = osty_q;
            ADR_STAT: reg_rdata = stat_q;
            ADR_MASK: reg_rdata = mask_q;
            ADR_DATA: reg_rdata = data_view;
            ADR_FAN:  reg_rdata = fan_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_xpdr_checker.sv
module gpio_xpdr_checker #(
    parameter int PIN_N = 8,
    parameter int FAN_N = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alert_n,
    input logic             alert_set,
    input logic             ara_ack,
    input logic             stat_rd,
    input logic [PIN_N-1:0] chg_in,
    input logic [PIN_N-1:0] stat_q,
    input logic [PIN_N-1:0] cfg_q,
    input logic [PIN_N-1:0] dir_q,
    input logic [PIN_N-1:0] fan_q,
    input logic [PIN_N-1:0] pin_oe,
    input logic [PIN_N-1:0] pin_out
);
    localparam int FAN_BASE = PIN_N - FAN_N;

    assert_no_alert_without_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_n) |-> $past(cfg_q[0]));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_ack && !alert_set) |=> alert_n);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (chg_in == '0)) |=> (stat_q == '0));

    assert_status_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && (chg_in == '0)) |=> $stable(stat_q));

    assert_fan_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[1] |-> ((pin_oe[PIN_N-1:FAN_BASE] == '1) &&
                      (pin_out[PIN_N-1:FAN_BASE] == ~fan_q[FAN_N-1:0])));

    assert_input_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[1]) |-> ((pin_oe & ~dir_q) == '0));

endmodule

bind gpio_xpdr_core gpio_xpdr_checker #(.PIN_N(PIN_N), .FAN_N(FAN_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alert_n   (alert_n),
    .alert_set (alert_set),
    .ara_ack   (ara_ack),
    .stat_rd   (stat_rd),
    .chg_in    (chg_in),
    .stat_q    (stat_q),
    .cfg_q     (cfg_q),
    .dir_q     (dir_q),
    .fan_q     (fan_q),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
);

// File: tb/sim_gpio_xpdr_core.sv
module sim_gpio_xpdr_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, ara_ack = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0, pin_in = '0;
    logic [7:0] reg_rdata, pin_oe, pin_out;
    logic       alert_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_xpdr_core u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ara_ack(ara_ack), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .alert_n(alert_n)
    );

    // {cfg, dir, style, data, fan, exp_oe, exp_out}
    localparam logic [55:0] VEC [6] = '{
        {8'h00, 8'hFF, 8'hFF, 8'hA5, 8'h00, 8'hFF, 8'hA5},
        {8'h00, 8'hFF, 8'h00, 8'hA5, 8'h00, 8'h5A, 8'h00},
        {8'h00, 8'h0F, 8'h05, 8'h3C, 8'h00, 8'h07, 8'h04},
        {8'h02, 8'h00, 8'h00, 8'h00, 8'h05, 8'hF0, 8'hA0},
        {8'h02, 8'hFF, 8'hFF, 8'h0F, 8'h0C, 8'hFF, 8'h3F},
        {8'h00, 8'hF0, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 alert_n", {7'd0, alert_n}, 8'h01);
        chk("R1 pin_oe", pin_oe, 8'h00);
        for (int a = 0; a < 7; a++) begin
            if (a != 5) begin
                rd(8'(a), v);
                chk("R1 reset reg", v, 8'h00);
            end
        end
        wr(8'h01, 8'hFF);
        rd(8'h05, v); chk("R1 data reset FF", v, 8'hFF);

        // drive table R3 R8
        for (int k = 0; k < 6; k++) begin
            wr(8'h00, VEC[k][55:48]);
            wr(8'h01, VEC[k][47:40]);
            wr(8'h02, VEC[k][39:32]);
            wr(8'h05, VEC[k][31:24]);
            wr(8'h06, VEC[k][23:16]);
            @(negedge clk);
            chk("R3/R8 pin_oe", pin_oe, VEC[k][15:8]);
            chk("R3/R8 pin_out", pin_out, VEC[k][7:0]);
        end

        wr(8'h00, 8'h00); wr(8'h01, 8'h00); wr(8'h02, 8'h00);
        wr(8'h05, 8'hFF); wr(8'h06, 8'h00);
        rd(8'h03, v); chk("R4 quiet status", v, 8'h00);

        // R2 map
        wr(8'h03, 8'hFF);
        rd(8'h03, v); chk("R2 status ignores write", v, 8'h00);
        wr(8'h07, 8'h77);
        rd(8'h07, v); chk("R2 unmapped reads 0", v, 8'h00);
        wr(8'h04, 8'h5A);
        rd(8'h04, v); chk("R2 mask readback", v, 8'h5A);

        // R11 latency, R6 alert
        wr(8'h04, 8'h01); wr(8'h00, 8'h01);
        @(negedge clk); pin_in = 8'h01;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 no alert after 2 edges", {7'd0, alert_n}, 8'h01);
        @(posedge clk); @(negedge clk);
        chk("R11 R6 alert on 3rd edge", {7'd0, alert_n}, 8'h00);
        rd(8'h03, v); chk("R4 rising sets status", v, 8'h01);
        chk("R7 read clears alert", {7'd0, alert_n}, 8'h01);

        // R4 with ie off
        wr(8'h00, 8'h00);
        set_pins(8'h03);
        chk("R6 ie off no alert", {7'd0, alert_n}, 8'h01);
        rd(8'h03, v); chk("R4 status with ie off", v, 8'h02);
        set_pins(8'h01);
        rd(8'h03, v); chk("R4 falling edge", v, 8'h02);

        // R6 mask off
        wr(8'h00, 8'h01);
        set_pins(8'h05);
        chk("R6 masked pin no alert", {7'd0, alert_n}, 8'h01);
        rd(8'h03, v); chk("R4 masked pin status", v, 8'h04);

        // R4 output pin ignored
        wr(8'h01, 8'h08);
        set_pins(8'h0D);
        chk("R6 output pin no alert", {7'd0, alert_n}, 8'h01);
        rd(8'h03, v); chk("R4 output pin no status", v, 8'h00);

        // R7 ara clears alert, not status
        set_pins(8'h0C);
        chk("R6 alert set", {7'd0, alert_n}, 8'h00);
        @(negedge clk); ara_ack = 1'b1;
        @(negedge clk); ara_ack = 1'b0;
        chk("R7 ara clears alert", {7'd0, alert_n}, 8'h01);
        rd(8'h03, v); chk("R7 ara keeps status", v, 8'h01);

        // R5 coincident change with status read
        set_pins(8'h0D);
        @(negedge clk); pin_in = 8'h09;
        repeat (2) @(posedge clk);
        rd(8'h03, v); chk("R5 read returns old", v, 8'h01);
        rd(8'h03, v); chk("R5 coincident change kept", v, 8'h04);

        // R7 coincident qualifying change with ara
        @(negedge clk); pin_in = 8'h08;
        repeat (2) @(posedge clk);
        @(negedge clk); ara_ack = 1'b1;
        @(negedge clk); ara_ack = 1'b0;
        chk("R7 set wins over ara", {7'd0, alert_n}, 8'h00);
        rd(8'h03, v); chk("R7 status after race", v, 8'h01);
        chk("R7 alert cleared by read", {7'd0, alert_n}, 8'h01);

        // R9 fan mode
        wr(8'h01, 8'h00); wr(8'h04, 8'hFF); wr(8'h00, 8'h03);
        rd(8'h03, v);
        set_pins(8'hF8);
        chk("R9 fan pins no alert", {7'd0, alert_n}, 8'h01);
        rd(8'h03, v); chk("R9 fan pins no status", v, 8'h00);
        set_pins(8'hF9);
        chk("R9 low pin alerts", {7'd0, alert_n}, 8'h00);
        rd(8'h03, v); chk("R9 low pin status", v, 8'h01);

        // R10 data view
        wr(8'h00, 8'h00); wr(8'h01, 8'h0F); wr(8'h05, 8'h0A);
        rd(8'h05, v); chk("R10 mixed data view", v, 8'hFA);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule